// File: doc/BRIEF.md
# Latched Real-Time Clock Registers

This block is the clock side of a cartridge bank controller. It keeps a running time of day (seconds, minutes, hours) and a 9-bit day count, advanced by a one-cycle pulse that arrives once per second. It also keeps a frozen copy of those counters, called the snapshot. The CPU reaches both through the external-RAM window. It writes a select code that maps one of five clock registers into that window, and then reads or writes the register at any window address.

A separate latch register controls which copy a read returns. Writing 0 and then 1 to it takes a new snapshot. Any nonzero stored value makes window reads return the snapshot instead of the running counters. The block also holds the 7-bit ROM bank number and the 2-bit RAM bank number that the rest of the bank controller uses.

Top module: `cart_rtc_bank`

## Requirements
- R1: After synchronous reset, the ROM bank is 1 and the RAM bank is 0. No clock register is selected, so `rtc_read_hit` is 0 and `bus_rdata` reads 0xFF. All running counters, the snapshot and the stored latch value are 0.
- R2: Each tick with halt clear advances the seconds. Seconds and minutes count 0 to 59 and hours count 0 to 23. Each rollover adds one to the next field, and an hours rollover adds one to the day count.
- R3: The day count is 9 bits wide. Register index 3 holds its low 8 bits. Bit 0 of register index 4 (the control register) holds its bit 8.
- R4: When the day count rolls over from 511 to 0, bit 7 of the control register is set. That bit stays set until a CPU write to the control register writes a 0 into it.
- R5: A write in 0x4000 to 0x5FFF with data 0x08 to 0x0C selects clock register index (data − 8): index 0 is seconds, 1 minutes, 2 hours, 3 day low, 4 control. Any other data deselects the clock and sets the RAM bank to data & 0x3.
- R6: A write in 0x6000 to 0x7FFF stores its data as the latch value. It copies the running counters into the snapshot only if the data is 1 and the stored latch value was 0.
- R7: While a clock register is selected and the address is in 0xA000 to 0xBFFF, `rtc_read_hit` is 1 and `bus_rdata` shows the selected register. The value comes from the snapshot if the latch value is nonzero, and from the running counters otherwise.
- R8: A write in 0xA000 to 0xBFFF while a clock register is selected loads the data into that running register. A tick in the same cycle is ignored.
- R9: While bit 6 of the control register is set, ticks do not change the counters. When the bit is cleared, counting resumes from the held value.
- R10: A write in 0x2000 to 0x3FFF sets the ROM bank to data & 0x7F, except that a result of 0 is stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Selected clock register, or 0xFF when there is no hit |
| rtc_read_hit | output | 1 | Clock register selected and address in the RAM window |
| rom_bank | output | 7 | Current ROM bank number |
| ram_bank | output | 2 | Current RAM bank number |

## Verification
The assertions assume several things about the inputs:
- `tick_1hz` is a single-cycle pulse.
- A CPU write lasts exactly one cycle.
- Stepping checks apply only while a counter field holds a legal value.

The counter assertions are guarded on field values below the rollover limit, so they cannot fire when software loads an out-of-range value. The stimulus follows these assumptions. It drives each write strobe and each tick for one cycle. It loads only legal field values, and it places ticks in their own cycles, except for one deliberate collision between a tick and a CPU write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 9;
    localparam int ROM_W    = 7;
    localparam int RAMB_W   = 2;
    localparam int REG_CNT  = 5;
    localparam int IDX_W    = $clog2(REG_CNT);
    localparam int SEL_BASE = 8;
    localparam int SEC_MAX  = 59;
    localparam int MIN_MAX  = 59;
    localparam int HR_MAX   = 23;

    localparam logic [IDX_W-1:0] IDX_SEC = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_MIN = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_HR  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_DAY = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_CTL = IDX_W'(4);

    // Control register bit positions (software decodes these)
    localparam int CTL_DAY8  = 0;
    localparam int CTL_HALT  = 6;
    localparam int CTL_CARRY = 7;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ROMSEL,
        RGN_BANKSEL,
        RGN_LATCH,
        RGN_WINDOW
    } region_e;

    typedef struct packed {
        logic             carry;
        logic             halt;
        logic [DAY_W-1:0] days;
        logic [HR_W-1:0]  hrs;
        logic [MIN_W-1:0] mins;
        logic [SEC_W-1:0] secs;
    } rtc_time_t;

    function automatic region_e region_of(input logic [2:0] top3);
        case (top3)
            3'b001:  return RGN_ROMSEL;
            3'b010:  return RGN_BANKSEL;
            3'b011:  return RGN_LATCH;
            3'b101:  return RGN_WINDOW;
            default: return RGN_NONE;
        endcase
    endfunction

    // One-second step with cascaded rollovers
    function automatic rtc_time_t rtc_advance(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.secs >= SEC_W'(SEC_MAX)) begin
            n.secs = '0;
            if (t.mins >= MIN_W'(MIN_MAX)) begin
                n.mins = '0;
                if (t.hrs >= HR_W'(HR_MAX)) begin
                    n.hrs = '0;
                    if (t.days == {DAY_W{1'b1}}) begin
                        n.days  = '0;
                        n.carry = 1'b1;
                    end else begin
                        n.days = t.days + DAY_W'(1);
                    end
                end else begin
                    n.hrs = t.hrs + HR_W'(1);
                end
            end else begin
                n.mins = t.mins + MIN_W'(1);
            end
        end else begin
            n.secs = t.secs + SEC_W'(1);
        end
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] rtc_get(input rtc_time_t t,
                                                  input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] v;
        v = '0;
        case (idx)
            IDX_SEC: v = DATA_W'(t.secs);
            IDX_MIN: v = DATA_W'(t.mins);
            IDX_HR:  v = DATA_W'(t.hrs);
            IDX_DAY: v = t.days[DATA_W-1:0];
            IDX_CTL: begin
                v[CTL_CARRY] = t.carry;
                v[CTL_HALT]  = t.halt;
                v[CTL_DAY8]  = t.days[DAY_W-1];
            end
            default: v = '1;
        endcase
        return v;
    endfunction

    function automatic rtc_time_t rtc_put(input rtc_time_t t,
                                          input logic [IDX_W-1:0] idx,
                                          input logic [DATA_W-1:0] d);
        rtc_time_t n;
        n = t;
        case (idx)
            IDX_SEC: n.secs = d[SEC_W-1:0];
            IDX_MIN: n.mins = d[MIN_W-1:0];
            IDX_HR:  n.hrs  = d[HR_W-1:0];
            IDX_DAY: n.days[DATA_W-1:0] = d;
            IDX_CTL: begin
                n.carry         = d[CTL_CARRY];
                n.halt          = d[CTL_HALT];
                n.days[DAY_W-1] = d[CTL_DAY8];
            end
            default: n = t;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_region_dec.sv
module rtc_region_dec
    import rtc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    logic unused_addr_low;
    assign unused_addr_low = ^addr[ADDR_W-4:0];
    assign region = region_of(addr[ADDR_W-1:ADDR_W-3]);
endmodule

// File: rtl/rtc_bank_ctrl.sv
module rtc_bank_ctrl
    import rtc_pkg::*;
#(
    parameter int BASE  = SEL_BASE,
    parameter int COUNT = REG_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output logic [ROM_W-1:0]  rom_bank,
    output logic [RAMB_W-1:0] ram_bank,
    output logic              clk_sel,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              latch_on,
    output logic              snap,
    output logic              win_wr
);
    localparam logic [DATA_W-1:0] SEL_LO = DATA_W'(BASE);
    localparam logic [DATA_W-1:0] SEL_HI = DATA_W'(BASE + COUNT - 1);

    logic [DATA_W-1:0] latch_q;
    logic              sel_is_clock;
    logic [ROM_W-1:0]  rom_req;
    logic [DATA_W-1:0] sel_off;

    assign sel_is_clock = (wdata >= SEL_LO) && (wdata <= SEL_HI);
    assign sel_off      = wdata - SEL_LO;
    assign rom_req      = wdata[ROM_W-1:0];
    assign snap     = wr && (region == RGN_LATCH) && (latch_q == '0) &&
                      (wdata == DATA_W'(1));
    assign win_wr   = wr && (region == RGN_WINDOW) && clk_sel;
    assign latch_on = (latch_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_bank <= ROM_W'(1);
            ram_bank <= '0;
            clk_sel  <= 1'b0;
            sel_idx  <= '0;
            latch_q  <= '0;
        end else if (wr) begin
            case (region)
                RGN_ROMSEL:  rom_bank <= (rom_req == '0) ? ROM_W'(1) : rom_req;
                RGN_BANKSEL: begin
                    if (sel_is_clock) begin
                        clk_sel <= 1'b1;
                        sel_idx <= sel_off[IDX_W-1:0];
                    end else begin
                        clk_sel  <= 1'b0;
                        ram_bank <= wdata[RAMB_W-1:0];
                    end
                end
                RGN_LATCH:   latch_q <= wdata;
                default:     ;
            endcase
        end
    end

    // R10
    a_r10_rom_write: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_ROMSEL) |=>
            (rom_bank == (($past(wdata[ROM_W-1:0]) == '0) ? ROM_W'(1)
                                                          : $past(wdata[ROM_W-1:0]))));
    // R5
    a_r5_clock_select: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_BANKSEL && sel_is_clock) |=>
            (clk_sel && sel_idx == IDX_W'($past(wdata) - SEL_LO)));
    a_r5_ram_select: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_BANKSEL && !sel_is_clock) |=>
            (!clk_sel && ram_bank == $past(wdata[RAMB_W-1:0])));
    // R6
    a_r6_latch_store: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_LATCH) |=> (latch_on == ($past(wdata) != '0)));
endmodule

// File: rtl/rtc_counter_core.sv
module rtc_counter_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    output rtc_time_t         live
);
    rtc_time_t nxt;

    always_comb begin
        nxt = live;
        if (ld)
            nxt = rtc_put(live, ld_idx, ld_data);
        else if (tick && !live.halt)
            nxt = rtc_advance(live);
    end

    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else     live <= nxt;
    end

    // R2
    a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && !live.halt && live.secs < SEC_W'(SEC_MAX)) |=>
            (live.secs == $past(live.secs) + SEC_W'(1) && $stable(live.mins)));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(live));
    // R9
    a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (live.halt && !ld) |=> $stable(live));
    // R4
    a_r4_carry_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(live.carry) |-> $past(ld && ld_idx == IDX_CTL));
    // R8
    a_r8_sec_load: assert property (@(posedge clk) disable iff (rst)
        (ld && ld_idx == IDX_SEC) |=> (live.secs == $past(ld_data[SEC_W-1:0])));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      snap,
    input  rtc_time_t live,
    output rtc_time_t held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (snap) held <= live;
    end

    // R6
    a_r6_copy: assert property (@(posedge clk) disable iff (rst)
        snap |=> (held == $past(live)));
    a_r6_keep: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held));
endmodule

// File: rtl/cart_rtc_bank.sv
module cart_rtc_bank
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rtc_read_hit,
    output logic [ROM_W-1:0]  rom_bank,
    output logic [RAMB_W-1:0] ram_bank
);
    region_e          region;
    logic             clk_sel;
    logic [IDX_W-1:0] sel_idx;
    logic             latch_on;
    logic             snap;
    logic             win_wr;
    rtc_time_t        live;
    rtc_time_t        held;
    rtc_time_t        view;

    rtc_region_dec u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    rtc_bank_ctrl #(.BASE(SEL_BASE), .COUNT(REG_CNT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .region   (region),
        .wdata    (bus_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .clk_sel  (clk_sel),
        .sel_idx  (sel_idx),
        .latch_on (latch_on),
        .snap     (snap),
        .win_wr   (win_wr)
    );

    rtc_counter_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .ld      (win_wr),
        .ld_idx  (sel_idx),
        .ld_data (bus_wdata),
        .live    (live)
    );

    rtc_snapshot u_snap (
        .clk  (clk),
        .rst  (rst),
        .snap (snap),
        .live (live),
        .held (held)
    );

    assign view         = latch_on ? held : live;
    assign rtc_read_hit = clk_sel && (region == RGN_WINDOW);
    assign bus_rdata    = rtc_read_hit ? rtc_get(view, sel_idx) : '1;

    // R7
    a_r7_no_hit_idle: assert property (@(posedge clk) disable iff (rst)
        !rtc_read_hit |-> (bus_rdata == '1));
    // R3
    a_r3_day_msb_view: assert property (@(posedge clk) disable iff (rst)
        (rtc_read_hit && !latch_on && sel_idx == IDX_CTL) |->
            (bus_rdata[CTL_DAY8] == live.days[DAY_W-1]));
endmodule

// File: tb/test_cart_rtc_bank.sv
module test_cart_rtc_bank;
    import rtc_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_TK  = 3'd2;
    localparam logic [2:0] OP_ROM = 3'd3;
    localparam logic [2:0] OP_RAM = 3'd4;
    localparam logic [2:0] OP_HIT = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 88;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, 16'h4000, 8'h08, 4'd5},   // R5 select seconds
        '{OP_RD, 16'hA000, 8'h00, 4'd1},   // R1 counters zero
        '{OP_TK, 16'h0000, 8'd5,  4'd2},
        '{OP_RD, 16'hA000, 8'h05, 4'd2},   // R2
        '{OP_WR, 16'hA000, 8'h3A, 4'd8},   // R8 secs = 58
        '{OP_TK, 16'h0000, 8'd2,  4'd2},
        '{OP_RD, 16'hA000, 8'h00, 4'd2},   // R2 sec wrap
        '{OP_WR, 16'h4000, 8'h09, 4'd5},
        '{OP_RD, 16'hA000, 8'h01, 4'd2},   // R2 minute carry
        '{OP_WR, 16'h6000, 8'h00, 4'd6},
        '{OP_WR, 16'h6000, 8'h01, 4'd6},   // R6 snapshot
        '{OP_TK, 16'h0000, 8'd60, 4'd7},
        '{OP_RD, 16'hA000, 8'h01, 4'd7},   // R7 latched view
        '{OP_WR, 16'h6000, 8'h00, 4'd7},
        '{OP_RD, 16'hA000, 8'h02, 4'd7},   // R7 live view
        '{OP_WR, 16'h2000, 8'h00, 4'd10},
        '{OP_ROM,16'h0000, 8'h01, 4'd10},  // R10 zero maps to one
        '{OP_WR, 16'h3FFF, 8'hFF, 4'd10},
        '{OP_ROM,16'h0000, 8'h7F, 4'd10},  // R10 masked
        '{OP_WR, 16'h2000, 8'h05, 4'd10},
        '{OP_ROM,16'h0000, 8'h05, 4'd10},
        '{OP_WR, 16'h5FFF, 8'h0D, 4'd5},
        '{OP_RAM,16'h0000, 8'h01, 4'd5},   // R5 0x0D -> ram bank 1
        '{OP_HIT,16'hA000, 8'h00, 4'd5},
        '{OP_RD, 16'hA000, 8'hFF, 4'd5},
        '{OP_WR, 16'h4000, 8'h07, 4'd5},
        '{OP_RAM,16'h0000, 8'h03, 4'd5},   // R5 0x07 -> ram bank 3
        '{OP_WR, 16'h4000, 8'h0A, 4'd2},
        '{OP_WR, 16'hA000, 8'h17, 4'd2},
        '{OP_WR, 16'h4000, 8'h09, 4'd2},
        '{OP_WR, 16'hA000, 8'h3B, 4'd2},
        '{OP_WR, 16'h4000, 8'h08, 4'd2},
        '{OP_WR, 16'hA000, 8'h3B, 4'd2},
        '{OP_TK, 16'h0000, 8'd1,  4'd2},
        '{OP_RD, 16'hBFFF, 8'h00, 4'd2},   // R2 full roll
        '{OP_WR, 16'h4000, 8'h0A, 4'd2},
        '{OP_RD, 16'hA000, 8'h00, 4'd2},
        '{OP_WR, 16'h4000, 8'h0B, 4'd3},
        '{OP_RD, 16'hA000, 8'h01, 4'd3},   // R3 day advanced
        '{OP_WR, 16'hA000, 8'hFF, 4'd3},
        '{OP_WR, 16'h4000, 8'h0A, 4'd3},
        '{OP_WR, 16'hA000, 8'h17, 4'd3},
        '{OP_WR, 16'h4000, 8'h09, 4'd3},
        '{OP_WR, 16'hA000, 8'h3B, 4'd3},
        '{OP_WR, 16'h4000, 8'h08, 4'd3},
        '{OP_WR, 16'hA000, 8'h3B, 4'd3},
        '{OP_TK, 16'h0000, 8'd1,  4'd3},
        '{OP_WR, 16'h4000, 8'h0B, 4'd3},
        '{OP_RD, 16'hA000, 8'h00, 4'd3},   // R3 day low after 255->256
        '{OP_WR, 16'h4000, 8'h0C, 4'd3},
        '{OP_RD, 16'hA000, 8'h01, 4'd3},   // R3 day bit 8
        '{OP_WR, 16'hA000, 8'h01, 4'd4},
        '{OP_WR, 16'h4000, 8'h0B, 4'd4},
        '{OP_WR, 16'hA000, 8'hFF, 4'd4},   // day 511
        '{OP_WR, 16'h4000, 8'h0A, 4'd4},
        '{OP_WR, 16'hA000, 8'h17, 4'd4},
        '{OP_WR, 16'h4000, 8'h09, 4'd4},
        '{OP_WR, 16'hA000, 8'h3B, 4'd4},
        '{OP_WR, 16'h4000, 8'h08, 4'd4},
        '{OP_WR, 16'hA000, 8'h3B, 4'd4},
        '{OP_TK, 16'h0000, 8'd1,  4'd4},
        '{OP_WR, 16'h4000, 8'h0C, 4'd4},
        '{OP_RD, 16'hA000, 8'h80, 4'd4},   // R4 carry set, day8 clear
        '{OP_WR, 16'h4000, 8'h0B, 4'd4},
        '{OP_RD, 16'hA000, 8'h00, 4'd4},
        '{OP_TK, 16'h0000, 8'd1,  4'd4},
        '{OP_WR, 16'h4000, 8'h0C, 4'd4},
        '{OP_RD, 16'hA000, 8'h80, 4'd4},   // R4 sticky
        '{OP_WR, 16'hA000, 8'h00, 4'd4},
        '{OP_RD, 16'hA000, 8'h00, 4'd4},   // R4 cleared by write
        '{OP_WR, 16'hA000, 8'h40, 4'd9},
        '{OP_RD, 16'hA000, 8'h40, 4'd9},
        '{OP_WR, 16'h4000, 8'h08, 4'd9},
        '{OP_WR, 16'hA000, 8'h10, 4'd9},
        '{OP_TK, 16'h0000, 8'd3,  4'd9},
        '{OP_RD, 16'hA000, 8'h10, 4'd9},   // R9 halted
        '{OP_WR, 16'h4000, 8'h0C, 4'd9},
        '{OP_WR, 16'hA000, 8'h00, 4'd9},
        '{OP_WR, 16'h4000, 8'h08, 4'd9},
        '{OP_TK, 16'h0000, 8'd1,  4'd9},
        '{OP_RD, 16'hA000, 8'h11, 4'd9},   // R9 resumed
        '{OP_WR, 16'h6000, 8'h02, 4'd6},
        '{OP_RD, 16'hA000, 8'h00, 4'd6},   // R6 no copy on 2, old snapshot shown
        '{OP_WR, 16'h6000, 8'h01, 4'd6},
        '{OP_RD, 16'hA000, 8'h00, 4'd6},   // R6 no copy, prior value nonzero
        '{OP_WR, 16'h6000, 8'h00, 4'd6},
        '{OP_WR, 16'h6000, 8'h01, 4'd6},
        '{OP_RD, 16'hA000, 8'h11, 4'd6}    // R6 fresh copy
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        rtc_read_hit;
    logic [6:0]  rom_bank;
    logic [1:0]  ram_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cart_rtc_bank i_cart_rtc_bank (
        .clk          (clk),
        .rst          (rst),
        .tick_1hz     (tick_1hz),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rtc_read_hit (rtc_read_hit),
        .rom_bank     (rom_bank),
        .ram_bank     (ram_bank)
    );

    task automatic check(input int req, input int got, input int exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic read_check(input logic [15:0] a, input logic [7:0] e,
                              input int req, input string what);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, e, what);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bus_addr = 16'hA000;
        #1;
        check(1, rom_bank, 1, "reset rom bank");
        check(1, ram_bank, 0, "reset ram bank");
        check(1, rtc_read_hit, 0, "reset hit");
        check(1, bus_rdata, 8'hFF, "reset rdata");

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR:  bus_write(VECS[i].addr, VECS[i].data);
                OP_TK:  pulse_ticks(int'(VECS[i].data));
                OP_RD:  read_check(VECS[i].addr, VECS[i].data, int'(VECS[i].req), "vector read");
                OP_ROM: begin @(negedge clk); check(int'(VECS[i].req), rom_bank, VECS[i].data, "rom bank"); end
                OP_RAM: begin @(negedge clk); check(int'(VECS[i].req), ram_bank, VECS[i].data, "ram bank"); end
                OP_HIT: begin
                    @(negedge clk); bus_addr = VECS[i].addr; #1;
                    check(int'(VECS[i].req), rtc_read_hit, VECS[i].data, "read hit");
                end
                default: ;
            endcase
        end

        // R7 hit flag high on a selected clock register
        @(negedge clk); bus_addr = 16'hB123; #1;
        check(7, rtc_read_hit, 1, "hit with clock selected");

        // R8 tick colliding with a seconds write is dropped
        bus_write(16'h6000, 8'h00);
        bus_write(16'h4000, 8'h08);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'hA000; bus_wdata = 8'h14; tick_1hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
        read_check(16'hA000, 8'h14, 8, "tick during write");

        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_addr = 16'hA000;
        #1;
        check(1, rom_bank, 1, "rerset rom bank");
        check(1, rtc_read_hit, 0, "rerset hit");
        bus_write(16'h4000, 8'h08);
        read_check(16'hA000, 8'h00, 1, "rerset seconds");

        finish_run();
    end
endmodule